// File: doc/BRIEF.md
# Shared Pending-Notification Bitmask

This block keeps one shared register for a group of nodes, holding one bit per node. Each bit does two jobs. It shows that a notification is waiting for its node, and it holds back further interrupts to that node. Every node has its own write port and can read the whole register. A node notifies a peer by writing a 1 into the peer's position. That 1 is ORed into the register.

A node whose bit goes from 0 to 1 receives a one-cycle interrupt pulse. The bit stays set while the node services the notification. The node then clears the bit by writing a 1 into its own position. A sender that reads the register and sees the receiver's bit already set does not need to send again: a second send would raise no interrupt.

Each write port carries a full-width vector. Slice n of the flattened data bus belongs to node n, and bit j of that slice addresses node j's position. Message payloads and queueing are left to the software that shares the memory.

Top module: `shared_pending_mask`

## Requirements
- R1: While reset is high, and on the first cycle after it, `rd_mask` and `irq` are all zero.
- R2: When node n has `wr_en[n]` high and `wr_data[n*NODES+j]` = 1 with j ≠ n, bit j of the register becomes 1 at that clock edge. Bits not addressed by any write keep their value.
- R3: `irq[j]` is high for exactly the one cycle that follows the edge at which bit j goes from 0 to 1.
- R4: When node j has `wr_en[j]` high and `wr_data[j*NODES+j]` = 1, bit j is cleared. A 0 in that position leaves the bit unchanged.
- R5: A set aimed at a bit that is already 1 leaves the bit at 1 and raises no interrupt.
- R6: A node cannot clear another node's bit. Whether it writes 1 or 0 into that position, a set bit stays set.
- R7: A 1 that a node writes into its own position never sets its own bit, so a node cannot interrupt itself.
- R8: When a set and a clear reach the same bit in the same cycle, the set wins. If the bit was 1, it stays 1 with no interrupt. If the bit was 0, it becomes 1 with an interrupt.
- R9: `rd_mask` shows the register as it stands after the previous clock edge. Writes presented during a cycle do not appear on it until the next edge.
- R10: When several nodes set the same 0 bit in the same cycle, the receiver gets a single one-cycle pulse.
- R11: Data on a port whose `wr_en` bit is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | NODES | Per-node write strobe |
| wr_data | input | NODES*NODES | Per-node write vectors; slice n belongs to node n |
| rd_mask | output | NODES | Registered pending bitmask, one bit per node |
| irq | output | NODES | Per-node interrupt pulse, registered |

## Verification
A write presented during a cycle takes effect at the next rising edge. Both the new `rd_mask` value and any `irq` pulse appear at that same edge, so every result is due exactly one edge after its stimulus. The bench drives each vector on a falling edge and checks `rd_mask` right away, confirming that the old value is still shown. It then checks both outputs on the following falling edge, one edge later. The table rows and the directed tests after them follow this single-edge schedule, including the next-cycle check that each pulse has ended.

// File: rtl/spm_pkg.sv
package spm_pkg;
  // Update request for one bit of the shared register.
  typedef struct packed {
    logic set;
    logic clr;
  } bit_req_t;
endpackage

// File: rtl/spm_write_decode.sv
module spm_write_decode #(
  parameter int NODES = 8
) (
  input  logic [NODES-1:0]       wr_en,
  input  logic [NODES*NODES-1:0] wr_data,
  output spm_pkg::bit_req_t      req [NODES]
);
  // For each target bit j: a set comes from any enabled foreign node,
  // a clear comes only from node j writing its own position.
  for (genvar j = 0; j < NODES; j++) begin : g_bit
    logic set_any;
    always_comb begin
      set_any = 1'b0;
      for (int n = 0; n < NODES; n++) begin
        if (n != j) set_any = set_any | (wr_en[n] & wr_data[n*NODES + j]);
      end
    end
    assign req[j].set = set_any;
    assign req[j].clr = wr_en[j] & wr_data[j*NODES + j];
  end
endmodule

// File: rtl/spm_pending_bit.sv
module spm_pending_bit (
  input  logic              clk,
  input  logic              rst,
  input  spm_pkg::bit_req_t req,
  output logic              bit_q,
  output logic              irq_q
);
  logic nxt;

  // Set has priority over clear so a notification is never dropped.
  assign nxt = req.set | (bit_q & ~req.clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      bit_q <= nxt;
      irq_q <= nxt & ~bit_q;
    end
  end

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (rst)
    req.set |=> bit_q);

  assert_owner_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (req.clr && !req.set) |=> !bit_q);

  assert_irq_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bit_q) |-> irq_q);

  assert_irq_single_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  assert_no_irq_when_high_R5: assert property (@(posedge clk) disable iff (rst)
    bit_q |=> !irq_q);

  assert_hold_without_request_R11: assert property (@(posedge clk) disable iff (rst)
    (!req.set && !req.clr) |=> $stable(bit_q));
endmodule

// File: rtl/shared_pending_mask.sv
module shared_pending_mask #(
  parameter int NODES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NODES-1:0]       wr_en,
  input  logic [NODES*NODES-1:0] wr_data,
  output logic [NODES-1:0]       rd_mask,
  output logic [NODES-1:0]       irq
);
  spm_pkg::bit_req_t req [NODES];

  spm_write_decode #(.NODES(NODES)) u_decode (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .req     (req)
  );

  for (genvar j = 0; j < NODES; j++) begin : g_node
    spm_pending_bit u_bit (
      .clk   (clk),
      .rst   (rst),
      .req   (req[j]),
      .bit_q (rd_mask[j]),
      .irq_q (irq[j])
    );
  end

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en == '0) |=> $stable(rd_mask));

  assert_irq_subset_R3: assert property (@(posedge clk) disable iff (rst)
    ((irq & ~rd_mask) == '0));
endmodule

// File: tb/shared_pending_mask_tb.sv
`timescale 1ns/1ps
module shared_pending_mask_tb;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   wr_en = '0;
  logic [N*N-1:0] wr_data = '0;
  logic [N-1:0]   rd_mask;
  logic [N-1:0]   irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shared_pending_mask #(.NODES(N)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_mask(rd_mask), .irq(irq)
  );

  // {wr_en[3:0], wr_data[15:0], expected rd_mask[3:0], expected irq[3:0]}
  localparam int NV = 14;
  localparam logic [27:0] VEC [NV] = '{
    {4'b0001, 16'h0002, 4'b0010, 4'b0010},
    {4'b0000, 16'h0000, 4'b0010, 4'b0000},
    {4'b0100, 16'h0200, 4'b0010, 4'b0000},
    {4'b0011, 16'h0000, 4'b0010, 4'b0000},
    {4'b0010, 16'h0020, 4'b0000, 4'b0000},
    {4'b0010, 16'h0020, 4'b0000, 4'b0000},
    {4'b1001, 16'h5004, 4'b0101, 4'b0101},
    {4'b0110, 16'h0440, 4'b0101, 4'b0000},
    {4'b0011, 16'h0081, 4'b1100, 4'b1000},
    {4'b1010, 16'h2020, 4'b1110, 4'b0010},
    {4'b1100, 16'h8400, 4'b0010, 4'b0000},
    {4'b0000, 16'hFFFF, 4'b0010, 4'b0000},
    {4'b1000, 16'hF000, 4'b0111, 4'b0101},
    {4'b0100, 16'h0000, 4'b0111, 4'b0000}
  };
  string tags [NV] = '{"R2", "R3", "R5", "R4", "R4", "R7", "R10",
                       "R8", "R2", "R8", "R4", "R11", "R6", "R6"};

  task automatic chk(input string req, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] prev;
    repeat (3) @(negedge clk);
    chk("R1", "mask in reset", rd_mask, '0);
    chk("R1", "irq in reset", irq, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "mask after reset", rd_mask, '0);
    chk("R1", "irq after reset", irq, '0);

    prev = '0;
    for (int i = 0; i < NV; i++) begin
      wr_en   = VEC[i][27:24];
      wr_data = VEC[i][23:8];
      #1;
      chk("R9", "mask before edge", rd_mask, prev);
      @(negedge clk);
      chk(tags[i], "mask", rd_mask, VEC[i][7:4]);
      chk(tags[i], "irq", irq, VEC[i][3:0]);
      prev = VEC[i][7:4];
    end
    wr_en = '0; wr_data = '0;

    // R1: reset in mid-operation clears pending bits
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "mask mid reset", rd_mask, '0);
    chk("R1", "irq mid reset", irq, '0);
    rst = 1'b0;
    @(negedge clk);

    // R7: broadcast from node 0 including its own position
    wr_en = 4'b0001; wr_data = 16'h000F;
    @(negedge clk);
    chk("R7", "broadcast mask", rd_mask, 4'b1110);
    chk("R7", "broadcast irq", irq, 4'b1110);
    wr_en = '0; wr_data = '0;
    @(negedge clk);
    chk("R3", "pulse ends", irq, '0);
    chk("R3", "mask held", rd_mask, 4'b1110);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule